// File: doc/BRIEF.md
# Dual-CPU Mailbox and Interrupt Controller

This block is the register file shared by one host processor and two secondary processors. It holds a sticky adapter-enable flag, an FM flag, a small ROM bank number, four transfer-address words, eight 16-bit mailbox words and the interrupt state of each secondary processor. Each side sees the same storage through its own view, and the read composition differs between the views. The host can start the adapter, choose the ROM bank, fill the transfer-address words and send a command interrupt to either secondary processor. A secondary processor sets its own interrupt mask and acknowledges interrupt sources by writing to dedicated clear addresses.

Four shared event sources arrive as single-cycle input pulses: reset request, vertical interrupt, horizontal interrupt and PWM. Each secondary processor also has its own command pending bit. The block gates all pending sources with that processor's mask and presents the result as a registered request vector. Mailbox writes from any side raise a one-cycle notification to the other sides, but only when the stored word actually changes. This lets waiting processors resume without polling on unchanged data.

Addresses are byte offsets within a 64-byte window, and register words are big-endian. A byte write to an odd offset carries the low byte of a word, and a byte write to an even offset carries the high byte. The data always sits in `wdata[7:0]` for byte writes.

Top module: `xcpu_mailbox`

## Requirements
- R1: After reset the adapter-enable flag is 0. A host byte write to offset 0x01 sets it, and only reset clears it. While it is 0, every other host write has no effect. This includes a host word write to offset 0x00. The flag reads back as bit 0 of the host view of offset 0x00.
- R2: A host write to the low byte of word 0x02 sets a command pending bit when the matching data bit is 1. The low byte is a byte write at 0x03 or a word write at 0x02. Data bit 0 targets secondary 0 and data bit 1 targets secondary 1. A data bit of 0 changes nothing.
- R3: A host write to the low byte of word 0x04 stores data bits 2:0 as the ROM bank. The low byte is a byte write at 0x05 or a word write at 0x04. `bank_chg` pulses for one cycle after the write only when the new bank differs from the stored one.
- R4: The eight mailbox words at offsets 0x20-0x2F accept word writes from the host and from both secondaries. All three views read back the stored value. Host byte writes to the mailbox are ignored.
- R5: When a write changes a mailbox word, a one-cycle pulse goes to the other sides, and never to the writer. `host_note` goes to the host and `sec_note[i]` goes to secondary i. A write of the value already stored raises no pulse.
- R6: When several sides write the same mailbox word in one cycle, the host wins over secondary 0, and secondary 0 wins over secondary 1. The losing writes are dropped and notify nobody. Writes to different words in the same cycle all take effect.
- R7: Secondary i sets its 4-bit mask from data bits 3:0. It does this by a byte write at 0x01 or a word write at 0x00. The other secondary's mask is untouched.
- R8: Secondary word writes clear pending sources as follows. Offset 0x14 clears reset, 0x16 clears vertical, 0x18 clears horizontal and 0x1C clears PWM, and these four are shared by both processors. Offset 0x1A clears only the writer's own command bit. Byte writes to these offsets do nothing.
- R9: When a source is set and cleared in the same cycle, the set wins and the bit stays pending.
- R10: `irq_req[5i+4:5i]` is {reset, vertical&m[3], horizontal&m[2], command&m[1], PWM&m[0]} for secondary i's mask m. It is registered, so it follows a pending or mask change one cycle later.
- R11: The host view of offset 0x00 is {FM, 14'b0, enable}. The secondary view of offset 0x00 is FM in bit 15, a constant 1 in bit 9 and the reader's own mask in bits 3:0. FM is written by a host word write at 0x00 (data bit 15) or a host byte write at 0x00 (data bit 7). The host view of offset 0x04 holds the bank in bits 2:0.
- R12: The four transfer-address words at 0x08-0x0F are written only by host word writes and are readable from all views. Secondary writes there are ignored. Reads of unmapped offsets return 0.
- R13: Read data appears on the clock edge that samples `*_rd_en` and holds until the next read. It shows the state from before any write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr_en | input | 1 | Host write strobe |
| host_wr_word | input | 1 | 1 = word write, 0 = byte write |
| host_addr | input | 6 | Host byte offset, used for read and write |
| host_wdata | input | 16 | Host write data |
| host_rd_en | input | 1 | Host read strobe |
| host_rdata | output | 16 | Registered host read data |
| sec_wr_en | input | 2 | Write strobe per secondary |
| sec_wr_word | input | 2 | Word/byte select per secondary |
| sec_addr | input | 12 | 6-bit offset per secondary, secondary i at [6i+5:6i] |
| sec_wdata | input | 32 | 16-bit write data per secondary |
| sec_rd_en | input | 2 | Read strobe per secondary |
| sec_rdata | output | 32 | Registered read data per secondary |
| ev_vres | input | 1 | Reset-request event pulse |
| ev_vint | input | 1 | Vertical interrupt event pulse |
| ev_hint | input | 1 | Horizontal interrupt event pulse |
| ev_pwm | input | 1 | PWM event pulse |
| irq_req | output | 10 | Masked request vector, 5 bits per secondary |
| rom_bank | output | 3 | Current ROM bank |
| bank_chg | output | 1 | One-cycle pulse on a bank change |
| host_note | output | 1 | Mailbox changed by a secondary |
| sec_note | output | 2 | Mailbox changed by another side, per secondary |

## Verification
The mask is swept through all sixteen values on each secondary while every source is pending. This tells a missing or shifted mask bit apart from a leak into the other processor. The clear addresses are then applied one at a time with hand-derived vectors, which separates shared sources from the per-processor command bit.

Every mailbox word is written by each of the three sides, then rewritten with the same value. This distinguishes real changes from redundant writes, and it shows which side is notified. Same-cycle collisions on one word and on distinct words check the priority order. A bank sequence with every value repeated separates change events from plain writes. The first writes issued before the adapter starts confirm that the gate holds.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int AW   = 6;
  localparam int DW   = 16;
  localparam int NSRC = 4;
  localparam int IRQW = NSRC + 1;

  localparam int SRC_PWM  = 0;
  localparam int SRC_CMD  = 1;
  localparam int SRC_HINT = 2;
  localparam int SRC_VINT = 3;

  // word indices (byte offset >> 1)
  localparam logic [4:0] W_CTRL     = 5'h00;
  localparam logic [4:0] W_CMD      = 5'h01;
  localparam logic [4:0] W_BANK     = 5'h02;
  localparam logic [4:0] W_CLR_VRES = 5'h0A;
  localparam logic [4:0] W_CLR_VINT = 5'h0B;
  localparam logic [4:0] W_CLR_HINT = 5'h0C;
  localparam logic [4:0] W_CLR_CMD  = 5'h0D;
  localparam logic [4:0] W_CLR_PWM  = 5'h0E;

  localparam logic [2:0] XFER_TAG = 3'b001;
  localparam logic [1:0] MBOX_TAG = 2'b10;

  typedef struct packed {
    logic          en;
    logic          word;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
  } wr_t;
endpackage

// File: rtl/mbx_host_regs.sv
module mbx_host_regs
  import mbx_pkg::*;
#(
  parameter int BANK_W = 3,
  parameter int XFER_N = 4,
  parameter int N_SEC  = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  wr_t                  hw,
  output logic                 en_q,
  output logic                 fm_q,
  output logic [BANK_W-1:0]    bank_q,
  output logic                 bank_evt_q,
  output logic [N_SEC-1:0]     cmd_set,
  output logic [XFER_N*DW-1:0] xfer_q,
  output logic                 host_ok
);
  localparam int XI_W = (XFER_N > 1) ? $clog2(XFER_N) : 1;

  logic [4:0]      widx;
  logic            lo_byte;
  logic            start_hit;
  logic            fm_hit;
  logic            fm_val;
  logic            bank_hit;
  logic            xfer_hit;
  logic [XI_W-1:0] xidx;

  assign widx      = hw.addr[AW-1:1];
  assign lo_byte   = hw.word | hw.addr[0];
  assign start_hit = hw.en & ~hw.word & (hw.addr == 6'h01) & ~en_q;
  assign host_ok   = hw.en & en_q;
  assign fm_hit    = host_ok & (widx == W_CTRL) & (hw.word | ~hw.addr[0]);
  assign fm_val    = hw.word ? hw.data[15] : hw.data[7];
  assign bank_hit  = host_ok & (widx == W_BANK) & lo_byte;
  assign xfer_hit  = host_ok & hw.word & (hw.addr[AW-1:3] == XFER_TAG);
  assign xidx      = hw.addr[XI_W:1];
  assign cmd_set   = (host_ok && widx == W_CMD && lo_byte) ? hw.data[N_SEC-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q       <= 1'b0;
      fm_q       <= 1'b0;
      bank_q     <= '0;
      bank_evt_q <= 1'b0;
    end else begin
      if (start_hit) en_q <= 1'b1;
      if (fm_hit) fm_q <= fm_val;
      bank_evt_q <= bank_hit && (hw.data[BANK_W-1:0] != bank_q);
      if (bank_hit) bank_q <= hw.data[BANK_W-1:0];
    end
  end

  for (genvar g = 0; g < XFER_N; g++) begin : g_xfer
    always_ff @(posedge clk) begin
      if (rst) xfer_q[g*DW +: DW] <= '0;
      else if (xfer_hit && xidx == XI_W'(g)) xfer_q[g*DW +: DW] <= hw.data;
    end
  end

  p_en_sticky_r1: assert property (@(posedge clk) disable iff (rst) $past(en_q) |-> en_q)
    else $error("adapter enable dropped");
  p_bank_evt_r3: assert property (@(posedge clk) disable iff (rst) bank_evt_q |-> bank_q != $past(bank_q))
    else $error("bank event without change");
  p_gate_r1: assert property (@(posedge clk) disable iff (rst) !$past(en_q) |-> $stable(bank_q))
    else $error("bank written while disabled");
endmodule

// File: rtl/mbx_mailbox.sv
module mbx_mailbox
  import mbx_pkg::*;
#(
  parameter int MBOX_N = 8,
  parameter int N_SEC  = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  wr_t                  hw,
  input  logic                 host_ok,
  input  wr_t                  sw [N_SEC],
  output logic [MBOX_N*DW-1:0] mbox_flat,
  output logic                 h_note_q,
  output logic [N_SEC-1:0]     s_note_q
);
  localparam int MI_W = (MBOX_N > 1) ? $clog2(MBOX_N) : 1;

  logic [MBOX_N-1:0][DW-1:0]    mem_q;
  logic [MBOX_N-1:0]            chg;
  logic [MBOX_N-1:0]            by_host;
  logic [MBOX_N-1:0][N_SEC-1:0] by_sec;
  logic                         h_note_n;
  logic [N_SEC-1:0]             s_note_n;

  for (genvar g = 0; g < MBOX_N; g++) begin : g_word
    logic             h_sel;
    logic [N_SEC-1:0] s_sel;
    logic             take;
    logic [DW-1:0]    wval;
    logic             win_h;
    logic [N_SEC-1:0] win_s;

    assign h_sel = host_ok & hw.word & (hw.addr[AW-1:4] == MBOX_TAG) &
                   (hw.addr[MI_W:1] == MI_W'(g));
    for (genvar i = 0; i < N_SEC; i++) begin : g_ssel
      assign s_sel[i] = sw[i].en & sw[i].word & (sw[i].addr[AW-1:4] == MBOX_TAG) &
                        (sw[i].addr[MI_W:1] == MI_W'(g));
    end

    always_comb begin
      take  = 1'b0;
      wval  = '0;
      win_h = 1'b0;
      win_s = '0;
      if (h_sel) begin
        take  = 1'b1;
        wval  = hw.data;
        win_h = 1'b1;
      end else begin
        for (int i = N_SEC - 1; i >= 0; i--) begin
          if (s_sel[i]) begin
            take     = 1'b1;
            wval     = sw[i].data;
            win_s    = '0;
            win_s[i] = 1'b1;
          end
        end
      end
    end

    assign chg[g]     = take && (wval != mem_q[g]);
    assign by_host[g] = win_h;
    assign by_sec[g]  = win_s;

    always_ff @(posedge clk) begin
      if (rst) mem_q[g] <= '0;
      else if (take) mem_q[g] <= wval;
    end
  end

  always_comb begin
    h_note_n = |(chg & ~by_host);
    s_note_n = '0;
    for (int j = 0; j < N_SEC; j++) begin
      for (int g = 0; g < MBOX_N; g++) begin
        if (chg[g] && (by_host[g] || (by_sec[g] != '0 && !by_sec[g][j])))
          s_note_n[j] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      h_note_q <= 1'b0;
      s_note_q <= '0;
    end else begin
      h_note_q <= h_note_n;
      s_note_q <= s_note_n;
    end
  end

  assign mbox_flat = mem_q;

  p_note_change_r5: assert property (@(posedge clk) disable iff (rst)
    (h_note_q || s_note_q != '0) |-> mem_q != $past(mem_q))
    else $error("mailbox note without a change");
  p_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    (mem_q == $past(mem_q)) |-> (!h_note_q && s_note_q == '0))
    else $error("mailbox unchanged yet notified");
endmodule

// File: rtl/mbx_src_pend.sv
module mbx_src_pend
  import mbx_pkg::*;
#(
  parameter int N_SEC = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       ev_vres,
  input  logic                       ev_vint,
  input  logic                       ev_hint,
  input  logic                       ev_pwm,
  input  logic [N_SEC-1:0][NSRC-1:0] clr_src,
  input  logic [N_SEC-1:0]           clr_vres,
  output logic [NSRC-1:0]            sh_q,
  output logic                       vres_q
);
  logic [NSRC-1:0] clr_any;
  logic [NSRC-1:0] set_v;
  logic            vres_clr;
  logic [NSRC-1:0] pend_q;

  always_comb begin
    clr_any = '0;
    for (int i = 0; i < N_SEC; i++) clr_any |= clr_src[i];
    clr_any[SRC_CMD] = 1'b0;
    set_v            = '0;
    set_v[SRC_PWM]   = ev_pwm;
    set_v[SRC_HINT]  = ev_hint;
    set_v[SRC_VINT]  = ev_vint;
  end
  assign vres_clr = |clr_vres;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      vres_q <= 1'b0;
    end else begin
      pend_q <= (pend_q & ~clr_any) | set_v;
      vres_q <= (vres_q & ~vres_clr) | ev_vres;
    end
  end

  always_comb begin
    sh_q          = pend_q;
    sh_q[SRC_CMD] = 1'b0;
  end

  p_vres_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (vres_q && !vres_clr) |=> vres_q)
    else $error("reset source lost without clear");
  p_vint_set_r9: assert property (@(posedge clk) disable iff (rst)
    ev_vint |=> sh_q[SRC_VINT])
    else $error("vertical event not latched");
endmodule

// File: rtl/mbx_cpu_irq.sv
module mbx_cpu_irq
  import mbx_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  wr_t             sw,
  input  logic            cmd_set,
  input  logic [NSRC-1:0] sh_q,
  input  logic            vres_q,
  output logic [NSRC-1:0] clr_src,
  output logic            clr_vres,
  output logic [NSRC-1:0] mask_q,
  output logic [IRQW-1:0] irq_q
);
  logic [4:0]      widx;
  logic            mask_hit;
  logic            cmd_clr;
  logic            cmd_q;
  logic [NSRC-1:0] pend;

  assign widx     = sw.addr[AW-1:1];
  assign mask_hit = sw.en & ((~sw.word & (sw.addr == 6'h01)) | (sw.word & (widx == W_CTRL)));
  assign cmd_clr  = sw.en & sw.word & (widx == W_CLR_CMD);
  assign clr_vres = sw.en & sw.word & (widx == W_CLR_VRES);

  always_comb begin
    clr_src           = '0;
    clr_src[SRC_PWM]  = sw.en & sw.word & (widx == W_CLR_PWM);
    clr_src[SRC_HINT] = sw.en & sw.word & (widx == W_CLR_HINT);
    clr_src[SRC_VINT] = sw.en & sw.word & (widx == W_CLR_VINT);
    pend              = sh_q;
    pend[SRC_CMD]     = cmd_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      cmd_q  <= 1'b0;
      irq_q  <= '0;
    end else begin
      if (mask_hit) mask_q <= sw.data[NSRC-1:0];
      cmd_q <= (cmd_q & ~cmd_clr) | cmd_set;
      irq_q <= {vres_q, pend & mask_q};
    end
  end

  p_mask_gate_r10: assert property (@(posedge clk) disable iff (rst)
    (irq_q[NSRC-1:0] & ~$past(mask_q)) == '0)
    else $error("request passed a cleared mask bit");
  p_own_ack_r8: assert property (@(posedge clk) disable iff (rst)
    (cmd_clr && !cmd_set) |=> !cmd_q)
    else $error("command not acknowledged");
  p_set_wins_r9: assert property (@(posedge clk) disable iff (rst)
    cmd_set |=> cmd_q)
    else $error("command set lost");
endmodule

// File: rtl/xcpu_mailbox.sv
module xcpu_mailbox
  import mbx_pkg::*;
#(
  parameter int N_SEC  = 2,
  parameter int MBOX_N = 8,
  parameter int XFER_N = 4,
  parameter int BANK_W = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  host_wr_en,
  input  logic                  host_wr_word,
  input  logic [AW-1:0]         host_addr,
  input  logic [DW-1:0]         host_wdata,
  input  logic                  host_rd_en,
  output logic [DW-1:0]         host_rdata,
  input  logic [N_SEC-1:0]      sec_wr_en,
  input  logic [N_SEC-1:0]      sec_wr_word,
  input  logic [N_SEC*AW-1:0]   sec_addr,
  input  logic [N_SEC*DW-1:0]   sec_wdata,
  input  logic [N_SEC-1:0]      sec_rd_en,
  output logic [N_SEC*DW-1:0]   sec_rdata,
  input  logic                  ev_vres,
  input  logic                  ev_vint,
  input  logic                  ev_hint,
  input  logic                  ev_pwm,
  output logic [N_SEC*IRQW-1:0] irq_req,
  output logic [BANK_W-1:0]     rom_bank,
  output logic                  bank_chg,
  output logic                  host_note,
  output logic [N_SEC-1:0]      sec_note
);
  localparam int MI_W = (MBOX_N > 1) ? $clog2(MBOX_N) : 1;
  localparam int XI_W = (XFER_N > 1) ? $clog2(XFER_N) : 1;

  wr_t                       hw;
  wr_t                       sw [N_SEC];
  logic                      en_q;
  logic                      fm_q;
  logic                      host_ok;
  logic [N_SEC-1:0]          cmd_set;
  logic [XFER_N*DW-1:0]      xfer_flat;
  logic [MBOX_N*DW-1:0]      mbox_flat;
  logic [DW-1:0]             xfer_w [XFER_N];
  logic [DW-1:0]             mbox_w [MBOX_N];
  logic [N_SEC-1:0][NSRC-1:0] clr_src;
  logic [N_SEC-1:0]          clr_vres;
  logic [NSRC-1:0]           sh_q;
  logic                      vres_q;
  logic [NSRC-1:0]           mask_q [N_SEC];
  logic [DW-1:0]             h_rd_n;

  assign hw = {host_wr_en, host_wr_word, host_addr, host_wdata};

  for (genvar g = 0; g < XFER_N; g++) begin : g_xw
    assign xfer_w[g] = xfer_flat[g*DW +: DW];
  end
  for (genvar g = 0; g < MBOX_N; g++) begin : g_mw
    assign mbox_w[g] = mbox_flat[g*DW +: DW];
  end

  mbx_host_regs #(.BANK_W(BANK_W), .XFER_N(XFER_N), .N_SEC(N_SEC)) u_host (
    .clk(clk), .rst(rst), .hw(hw), .en_q(en_q), .fm_q(fm_q), .bank_q(rom_bank),
    .bank_evt_q(bank_chg), .cmd_set(cmd_set), .xfer_q(xfer_flat), .host_ok(host_ok)
  );

  mbx_mailbox #(.MBOX_N(MBOX_N), .N_SEC(N_SEC)) u_mbox (
    .clk(clk), .rst(rst), .hw(hw), .host_ok(host_ok), .sw(sw),
    .mbox_flat(mbox_flat), .h_note_q(host_note), .s_note_q(sec_note)
  );

  mbx_src_pend #(.N_SEC(N_SEC)) u_pend (
    .clk(clk), .rst(rst), .ev_vres(ev_vres), .ev_vint(ev_vint), .ev_hint(ev_hint),
    .ev_pwm(ev_pwm), .clr_src(clr_src), .clr_vres(clr_vres), .sh_q(sh_q), .vres_q(vres_q)
  );

  for (genvar i = 0; i < N_SEC; i++) begin : g_sec
    logic [DW-1:0] s_rd_n;
    logic [AW-1:0] a;

    assign sw[i] = {sec_wr_en[i], sec_wr_word[i], sec_addr[i*AW +: AW], sec_wdata[i*DW +: DW]};
    assign a     = sec_addr[i*AW +: AW];

    mbx_cpu_irq u_irq (
      .clk(clk), .rst(rst), .sw(sw[i]), .cmd_set(cmd_set[i]), .sh_q(sh_q), .vres_q(vres_q),
      .clr_src(clr_src[i]), .clr_vres(clr_vres[i]), .mask_q(mask_q[i]),
      .irq_q(irq_req[i*IRQW +: IRQW])
    );

    always_comb begin
      s_rd_n = '0;
      if (a[AW-1:1] == W_CTRL) begin
        s_rd_n[15]       = fm_q;
        s_rd_n[9]        = 1'b1;
        s_rd_n[NSRC-1:0] = mask_q[i];
      end else if (a[AW-1:3] == XFER_TAG) begin
        s_rd_n = xfer_w[a[XI_W:1]];
      end else if (a[AW-1:4] == MBOX_TAG) begin
        s_rd_n = mbox_w[a[MI_W:1]];
      end
    end

    always_ff @(posedge clk) begin
      if (rst) sec_rdata[i*DW +: DW] <= '0;
      else if (sec_rd_en[i]) sec_rdata[i*DW +: DW] <= s_rd_n;
    end
  end

  always_comb begin
    h_rd_n = '0;
    if (host_addr[AW-1:1] == W_CTRL) begin
      h_rd_n[15] = fm_q;
      h_rd_n[0]  = en_q;
    end else if (host_addr[AW-1:1] == W_BANK) begin
      h_rd_n[BANK_W-1:0] = rom_bank;
    end else if (host_addr[AW-1:3] == XFER_TAG) begin
      h_rd_n = xfer_w[host_addr[XI_W:1]];
    end else if (host_addr[AW-1:4] == MBOX_TAG) begin
      h_rd_n = mbox_w[host_addr[MI_W:1]];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) host_rdata <= '0;
    else if (host_rd_en) host_rdata <= h_rd_n;
  end
endmodule

// File: tb/test_xcpu_mailbox.sv
module test_xcpu_mailbox;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        host_wr_en, host_wr_word, host_rd_en;
  logic [5:0]  host_addr;
  logic [15:0] host_wdata, host_rdata;
  logic [1:0]  sec_wr_en, sec_wr_word, sec_rd_en;
  logic [11:0] sec_addr;
  logic [31:0] sec_wdata, sec_rdata;
  logic        ev_vres, ev_vint, ev_hint, ev_pwm;
  logic [9:0]  irq_req;
  logic [2:0]  rom_bank;
  logic        bank_chg, host_note;
  logic [1:0]  sec_note;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  done   = 0;
  logic       cap_bank;
  logic [2:0] cap_note;

  always #(CLK_P/2) clk = ~clk;

  xcpu_mailbox i_xcpu_mailbox (
    .clk(clk), .rst(rst), .host_wr_en(host_wr_en), .host_wr_word(host_wr_word),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rd_en(host_rd_en),
    .host_rdata(host_rdata), .sec_wr_en(sec_wr_en), .sec_wr_word(sec_wr_word),
    .sec_addr(sec_addr), .sec_wdata(sec_wdata), .sec_rd_en(sec_rd_en),
    .sec_rdata(sec_rdata), .ev_vres(ev_vres), .ev_vint(ev_vint), .ev_hint(ev_hint),
    .ev_pwm(ev_pwm), .irq_req(irq_req), .rom_bank(rom_bank), .bank_chg(bank_chg),
    .host_note(host_note), .sec_note(sec_note)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    host_wr_en = 0; host_wr_word = 0; host_addr = '0; host_wdata = '0; host_rd_en = 0;
    sec_wr_en = '0; sec_wr_word = '0; sec_addr = '0; sec_wdata = '0; sec_rd_en = '0;
    ev_vres = 0; ev_vint = 0; ev_hint = 0; ev_pwm = 0;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_host(input logic word, input logic [5:0] a, input logic [15:0] d);
    host_wr_en = 1; host_wr_word = word; host_addr = a; host_wdata = d;
  endtask

  task automatic set_sec(input int i, input logic word, input logic [5:0] a, input logic [15:0] d);
    sec_wr_en[i] = 1'b1; sec_wr_word[i] = word; sec_addr[i*6 +: 6] = a; sec_wdata[i*16 +: 16] = d;
  endtask

  task automatic fire();
    tick();
    cap_bank = bank_chg;
    cap_note = {host_note, sec_note};
    idle();
  endtask

  task automatic host_wr(input logic word, input logic [5:0] a, input logic [15:0] d);
    set_host(word, a, d);
    fire();
  endtask

  task automatic sec_wr(input int i, input logic word, input logic [5:0] a, input logic [15:0] d);
    set_sec(i, word, a, d);
    fire();
  endtask

  task automatic host_rd(input logic [5:0] a, output logic [15:0] v);
    host_addr = a; host_rd_en = 1;
    tick();
    v = host_rdata;
    idle();
  endtask

  task automatic sec_rd(input int i, input logic [5:0] a, output logic [15:0] v);
    sec_addr[i*6 +: 6] = a; sec_rd_en[i] = 1'b1;
    tick();
    v = sec_rdata[i*16 +: 16];
    idle();
  endtask

  function automatic logic [4:0] irq_of(input int i);
    return irq_req[i*5 +: 5];
  endfunction

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    logic [15:0] val;
    logic [2:0]  bprev;
    logic [2:0]  bv;
    idle();
    rst = 1;
    repeat (3) tick();
    rst = 0;
    tick();

    // reset state
    host_rd(6'h00, v);        chk("R1 reset ctrl", v, 16'h0000);
    chk("R10 reset irq", irq_req, 10'h000);
    chk("R3 reset bank", rom_bank, 3'd0);
    sec_rd(0, 6'h00, v);      chk("R11 reset sec ctrl", v, 16'h0200);

    // gating before the adapter starts
    sec_wr(0, 1'b0, 6'h01, 16'h000F);
    sec_wr(1, 1'b0, 6'h01, 16'h000F);
    host_wr(1'b1, 6'h04, 16'h0005);
    chk("R1 bank gated", rom_bank, 3'd0);
    chk("R1 bank evt gated", cap_bank, 1'b0);
    host_wr(1'b1, 6'h20, 16'hBEEF);
    chk("R1 mbox note gated", cap_note, 3'b000);
    host_rd(6'h20, v);        chk("R1 mbox gated", v, 16'h0000);
    host_wr(1'b0, 6'h03, 16'h0003);
    tick();
    chk("R1 cmd gated", irq_req, 10'h000);
    host_wr(1'b1, 6'h00, 16'h8001);
    host_rd(6'h00, v);        chk("R1 word 0 gated", v, 16'h0000);
    host_wr(1'b0, 6'h01, 16'h0001);
    host_rd(6'h00, v);        chk("R1 enable set", v, 16'h0001);

    // read shows state before a same-cycle write
    set_host(1'b1, 6'h22, 16'h1234);
    host_rd_en = 1;
    fire();
    chk("R13 read before write", host_rdata, 16'h0000);
    host_rd(6'h22, v);        chk("R13 read after write", v, 16'h1234);

    // FM flag in both views
    host_wr(1'b1, 6'h00, 16'h8000);
    host_rd(6'h00, v);        chk("R11 host fm", v, 16'h8001);
    sec_rd(1, 6'h00, v);      chk("R11 sec fm", v, 16'h820F);
    host_wr(1'b0, 6'h00, 16'h0000);
    host_rd(6'h00, v);        chk("R11 host fm byte clear", v, 16'h0001);

    // bank sweep with repeats
    bprev = 3'd0;
    for (int k = 0; k < 16; k++) begin
      bv = 3'((k >> 1) & 7);
      if (k % 2 == 0) host_wr(1'b0, 6'h05, 16'h00F8 | 16'(bv));
      else            host_wr(1'b1, 6'h04, 16'hFFF8 | 16'(bv));
      chk("R3 bank evt", cap_bank, (bv != bprev));
      chk("R3 bank value", rom_bank, bv);
      host_rd(6'h04, v);      chk("R11 bank read", v, 16'(bv));
      bprev = bv;
    end

    // all sources pending, then mask sweep
    set_host(1'b0, 6'h03, 16'h0003);
    ev_vres = 1; ev_vint = 1; ev_hint = 1; ev_pwm = 1;
    fire();
    tick();
    chk("R10 all pending", irq_req, 10'h3FF);
    chk("R2 both cmd", {irq_of(1)[1], irq_of(0)[1]}, 2'b11);
    for (int i = 0; i < 2; i++) begin
      for (int m = 0; m < 16; m++) begin
        if (m % 2 == 0) sec_wr(i, 1'b0, 6'h01, 16'h00F0 | 16'(m));
        else            sec_wr(i, 1'b1, 6'h00, 16'hABC0 | 16'(m));
        tick();
        chk("R7 R10 masked req", irq_of(i), {1'b1, 4'(m)});
        chk("R7 other cpu", irq_of(1 - i), 5'h1F);
        sec_rd(i, 6'h00, v);  chk("R11 sec mask read", v, 16'h0200 | 16'(m));
      end
      sec_wr(i, 1'b0, 6'h01, 16'h000F);
    end

    // clears: shared sources versus own command
    sec_wr(0, 1'b1, 6'h1A, 16'h0); tick();
    chk("R8 own cmd cpu0", irq_of(0), 5'h1D);  chk("R8 cmd kept cpu1", irq_of(1), 5'h1F);
    sec_wr(1, 1'b1, 6'h18, 16'h0); tick();
    chk("R8 hint cpu0", irq_of(0), 5'h19);     chk("R8 hint cpu1", irq_of(1), 5'h1B);
    sec_wr(0, 1'b1, 6'h16, 16'h0); tick();
    chk("R8 vint cpu0", irq_of(0), 5'h11);     chk("R8 vint cpu1", irq_of(1), 5'h13);
    sec_wr(1, 1'b1, 6'h1C, 16'h0); tick();
    chk("R8 pwm cpu0", irq_of(0), 5'h10);      chk("R8 pwm cpu1", irq_of(1), 5'h12);
    sec_wr(0, 1'b1, 6'h14, 16'h0); tick();
    chk("R8 vres cpu0", irq_of(0), 5'h00);     chk("R8 vres cpu1", irq_of(1), 5'h02);
    sec_wr(1, 1'b1, 6'h1A, 16'h0); tick();
    chk("R8 own cmd cpu1", irq_of(1), 5'h00);
    host_wr(1'b0, 6'h03, 16'h0001); tick();
    chk("R2 cmd cpu0 only", irq_req, 10'h002);
    sec_wr(0, 1'b0, 6'h1B, 16'h0000); tick();
    chk("R8 byte clear ignored", irq_of(0), 5'h02);
    sec_wr(0, 1'b1, 6'h1A, 16'h0); tick();
    chk("R8 cmd cleared", irq_req, 10'h000);
    host_wr(1'b1, 6'h02, 16'h0002); tick();
    chk("R2 word cmd cpu1", irq_req, 10'h040);
    sec_wr(1, 1'b1, 6'h1A, 16'h0); tick();

    // set wins over clear
    set_host(1'b0, 6'h03, 16'h0001);
    set_sec(0, 1'b1, 6'h1A, 16'h0);
    fire(); tick();
    chk("R9 cmd set wins", irq_of(0), 5'h02);
    ev_hint = 1;
    set_sec(1, 1'b1, 6'h18, 16'h0);
    fire(); tick();
    chk("R9 hint set wins cpu1", irq_of(1), 5'h04);
    chk("R9 hint set wins cpu0", irq_of(0), 5'h06);
    sec_wr(0, 1'b1, 6'h1A, 16'h0);
    sec_wr(0, 1'b1, 6'h18, 16'h0); tick();
    chk("R8 cleanup", irq_req, 10'h000);

    // mailbox sweep: each word, each writer, then a redundant rewrite
    for (int w = 0; w < 8; w++) begin
      for (int s = 0; s < 3; s++) begin
        val = (16'h1111 * 16'(s + 1)) ^ {8'(w), 8'h00};
        if (s == 0) host_wr(1'b1, 6'(6'h20 + 2 * w), val);
        else        sec_wr(s - 1, 1'b1, 6'(6'h20 + 2 * w), val);
        chk("R5 note on change", cap_note, (s == 0) ? 3'b011 : ((s == 1) ? 3'b110 : 3'b101));
        if (s == 0) host_wr(1'b1, 6'(6'h20 + 2 * w), val);
        else        sec_wr(s - 1, 1'b1, 6'(6'h20 + 2 * w), val);
        chk("R5 no note on same value", cap_note, 3'b000);
        host_rd(6'(6'h20 + 2 * w), v); chk("R4 host view", v, val);
        sec_rd(0, 6'(6'h20 + 2 * w), v); chk("R4 sec0 view", v, val);
        sec_rd(1, 6'(6'h21 + 2 * w), v); chk("R4 sec1 view", v, val);
      end
    end
    host_wr(1'b0, 6'h21, 16'h0055);
    chk("R4 host byte ignored note", cap_note, 3'b000);
    host_rd(6'h20, v);        chk("R4 host byte ignored", v, 16'h3333);

    // collisions
    set_host(1'b1, 6'h26, 16'hC001);
    set_sec(0, 1'b1, 6'h26, 16'hC002);
    set_sec(1, 1'b1, 6'h26, 16'hC003);
    fire();
    chk("R6 host wins note", cap_note, 3'b011);
    sec_rd(1, 6'h26, v);      chk("R6 host wins value", v, 16'hC001);
    set_sec(0, 1'b1, 6'h2A, 16'hD002);
    set_sec(1, 1'b1, 6'h2A, 16'hD003);
    fire();
    chk("R6 sec0 wins note", cap_note, 3'b110);
    host_rd(6'h2A, v);        chk("R6 sec0 wins value", v, 16'hD002);
    set_sec(0, 1'b1, 6'h2C, 16'hE006);
    set_sec(1, 1'b1, 6'h2E, 16'hE007);
    fire();
    chk("R6 distinct words note", cap_note, 3'b111);
    host_rd(6'h2C, v);        chk("R6 word6", v, 16'hE006);
    host_rd(6'h2E, v);        chk("R6 word7", v, 16'hE007);

    // transfer-address words and unmapped reads
    for (int k = 0; k < 4; k++) host_wr(1'b1, 6'(6'h08 + 2 * k), 16'h5A00 + 16'(k));
    for (int k = 0; k < 4; k++) begin
      host_rd(6'(6'h08 + 2 * k), v);  chk("R12 host xfer", v, 16'h5A00 + 16'(k));
      sec_rd(0, 6'(6'h08 + 2 * k), v); chk("R12 sec0 xfer", v, 16'h5A00 + 16'(k));
      sec_rd(1, 6'(6'h08 + 2 * k), v); chk("R12 sec1 xfer", v, 16'h5A00 + 16'(k));
    end
    sec_wr(0, 1'b1, 6'h0A, 16'hFFFF);
    host_rd(6'h0A, v);        chk("R12 sec write ignored", v, 16'h5A01);
    sec_rd(0, 6'h30, v);      chk("R12 unmapped sec0", v, 16'h0000);
    sec_rd(1, 6'h12, v);      chk("R12 unmapped sec1", v, 16'h0000);
    host_rd(6'h06, v);        chk("R12 unmapped host", v, 16'h0000);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule